// File: doc/BRIEF.md
# Floating-point status register update unit

This unit holds the condition, exception and accrued-exception fields of a floating-point status word, together with the trap-enable byte of the matching control word. When an operation finishes, the datapath presents a result descriptor and the exception flags that the operation raised. The descriptor holds a sign bit and a class code: finite number, zero, infinity, quiet NaN or signalling NaN. In the next clock edge the unit rebuilds the condition nibble, updates the exception byte, ORs newly implied flags into the sticky accrued field, and raises a trap request when any exception flag that is set is also enabled.

Software reaches both words through a single register port, which writes on a strobe and reads combinationally. A select bit picks the status word or the control word. A write and a result update in the same cycle resolve in favour of the write. The exception byte is either replaced or accumulated, as the issuing operation requests: an arithmetic operation starts with a clear exception byte. A compare or test uses the same update path, because it changes only the status and writes no destination.

Top module: `fpsr_unit`

## Requirements
- R1: After a synchronous reset the status word, the control word and `trap_req` are all zero.
- R2: Every accepted update clears the four condition bits and then sets new ones. N (bit 27) equals `upd_sign` for any class. Z (bit 26) is set for class zero (code 1). I (bit 25) is set for class infinity (code 2). A finite number (code 0) sets neither Z nor I.
- R3: A quiet-NaN result (code 3) sets only NaN (bit 24). A signalling-NaN result (code 4) sets NaN and also sets the SNAN exception flag (bit 14).
- R4: The exception byte is at bits 15..8, ordered BSUN, SNAN, OPERR, OVFL, UNFL, DZ, INEX2, INEX1 from high to low. With `upd_clr_exc`=1 an update replaces the byte with `upd_exc` (same order). With `upd_clr_exc`=0 it ORs `upd_exc` into the byte.
- R5: Accrued invalid (bit 7) is set when the updated exception byte has BSUN, SNAN or OPERR set.
- R6: Accrued overflow (bit 6) is set by OVFL, and accrued divide-by-zero (bit 4) is set by DZ.
- R7: Accrued underflow (bit 5) is set only when UNFL and INEX2 are both set. UNFL alone leaves it clear.
- R8: Accrued inexact (bit 3) is set by INEX1, by INEX2 or by OVFL.
- R9: Accrued bits are sticky. Updates only OR into them, and only a write to the status word clears them.
- R10: `trap_req` is high exactly when the AND of the exception byte and the enable byte (control bits 15..8, same order) is nonzero. It follows the stored state, so it changes in the cycle after the update or write that caused it.
- R11: When `reg_we` is high, the update presented in that cycle is discarded and the write alone takes effect.
- R12: `reg_sel`=0 selects the status word and `reg_sel`=1 selects the control word. Only the defined bits are stored: status mask 0x0F00FFF8, control mask 0x0000FF00. Other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Result update strobe |
| upd_sign | input | 1 | Sign of the result |
| upd_class | input | 3 | Result class: 0 number, 1 zero, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| upd_exc | input | 8 | Exception flags raised by the operation |
| upd_clr_exc | input | 1 | 1: replace the exception byte, 0: accumulate into it |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 status word, 1 control word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| trap_req | output | 1 | Enabled exception pending |

## Verification
Every stored bit can be read at the port in the cycle after the update or write that changed it, so a fault in the condition or exception logic shows in the next read of the status word. A wrong accrued term can stay hidden until a later operation, because the accrued bits are sticky. For that reason the checks start from a cleared status word, and the accumulation and stickiness sequences look for a bit that is set or lost one update later. A fault in the enable path shows on `trap_req` one cycle after the flag reaches the exception byte.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
    localparam int REG_W   = 32;
    localparam int CC_W    = 4;
    localparam int EXC_W   = 8;
    localparam int ACC_W   = 5;
    localparam int CLS_W   = 3;
    localparam int CC_LSB  = 24;
    localparam int EXC_LSB = 8;
    localparam int ACC_LSB = 3;
    localparam int EN_LSB  = 8;

    localparam logic [REG_W-1:0] STATUS_MASK =
        ((REG_W'(1) << CC_W) - 1) << CC_LSB |
        ((REG_W'(1) << EXC_W) - 1) << EXC_LSB |
        ((REG_W'(1) << ACC_W) - 1) << ACC_LSB;
    localparam logic [REG_W-1:0] CTRL_MASK =
        ((REG_W'(1) << EXC_W) - 1) << EN_LSB;

    typedef enum logic [CLS_W-1:0] {
        CLS_NUM  = 3'd0,
        CLS_ZERO = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } res_class_e;

    typedef struct packed {
        logic sign;
        res_class_e cls;
    } result_t;

    typedef struct packed {
        logic n;
        logic z;
        logic i;
        logic nan;
    } cc_t;

    typedef struct packed {
        logic bsun;
        logic snan;
        logic operr;
        logic ovfl;
        logic unfl;
        logic dz;
        logic inex2;
        logic inex1;
    } exc_t;

    typedef struct packed {
        logic iop;
        logic ovfl;
        logic unfl;
        logic dz;
        logic inex;
    } acc_t;

    function automatic logic [REG_W-1:0] pack_status(cc_t c, exc_t e, acc_t a);
        logic [REG_W-1:0] w;
        w = '0;
        w[CC_LSB  +: CC_W]  = c;
        w[EXC_LSB +: EXC_W] = e;
        w[ACC_LSB +: ACC_W] = a;
        return w;
    endfunction
endpackage

// File: rtl/fpsr_cc_gen.sv
module fpsr_cc_gen
    import fpsr_pkg::*;
(
    input  result_t res,
    output cc_t     cc,
    output logic    snan_evt
);
    always_comb begin
        cc       = '0;
        snan_evt = 1'b0;
        cc.n     = res.sign;
        unique case (res.cls)
            CLS_ZERO: cc.z = 1'b1;
            CLS_INF:  cc.i = 1'b1;
            CLS_QNAN: cc.nan = 1'b1;
            CLS_SNAN: begin
                cc.nan   = 1'b1;
                snan_evt = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fpsr_accrue.sv
module fpsr_accrue
    import fpsr_pkg::*;
(
    input  exc_t exc,
    output acc_t acc_set
);
    always_comb begin
        acc_set      = '0;
        acc_set.iop  = exc.bsun | exc.snan | exc.operr;
        acc_set.ovfl = exc.ovfl;
        acc_set.unfl = exc.unfl & exc.inex2;
        acc_set.dz   = exc.dz;
        acc_set.inex = exc.inex1 | exc.inex2 | exc.ovfl;
    end
endmodule

// File: rtl/fpsr_trap_chk.sv
module fpsr_trap_chk #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] enables,
    output logic         trap
);
    logic [W:0] chain;
    assign chain[0] = 1'b0;
    for (genvar k = 0; k < W; k++) begin : g_or
        assign chain[k+1] = chain[k] | (flags[k] & enables[k]);
    end
    assign trap = chain[W];
endmodule

// File: rtl/fpsr_unit.sv
module fpsr_unit
    import fpsr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_valid,
    input  logic                 upd_sign,
    input  logic [CLS_W-1:0]     upd_class,
    input  logic [EXC_W-1:0]     upd_exc,
    input  logic                 upd_clr_exc,
    input  logic                 reg_we,
    input  logic                 reg_sel,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 trap_req
);
    cc_t              cc_q;
    exc_t             exc_q;
    acc_t             acc_q;
    logic [EXC_W-1:0] en_q;

    result_t          res_in;
    cc_t              cc_new;
    logic             snan_evt;
    exc_t             exc_nxt;
    acc_t             acc_set;
    logic [REG_W-1:0] status_word;
    logic [REG_W-1:0] ctrl_word;

    assign res_in.sign = upd_sign;
    assign res_in.cls  = res_class_e'(upd_class);

    fpsr_cc_gen u_cc (
        .res      (res_in),
        .cc       (cc_new),
        .snan_evt (snan_evt)
    );

    always_comb begin
        exc_nxt      = upd_clr_exc ? exc_t'('0) : exc_q;
        exc_nxt      = exc_t'(exc_nxt | exc_t'(upd_exc));
        exc_nxt.snan = exc_nxt.snan | snan_evt;
    end

    fpsr_accrue u_acc (
        .exc     (exc_nxt),
        .acc_set (acc_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cc_q  <= '0;
            exc_q <= '0;
            acc_q <= '0;
            en_q  <= '0;
        end else if (reg_we) begin
            if (!reg_sel) begin
                cc_q  <= cc_t'(reg_wdata[CC_LSB +: CC_W]);
                exc_q <= exc_t'(reg_wdata[EXC_LSB +: EXC_W]);
                acc_q <= acc_t'(reg_wdata[ACC_LSB +: ACC_W]);
            end else begin
                en_q  <= reg_wdata[EN_LSB +: EXC_W];
            end
        end else if (upd_valid) begin
            cc_q  <= cc_new;
            exc_q <= exc_nxt;
            acc_q <= acc_t'(acc_q | acc_set);
        end
    end

    assign status_word = pack_status(cc_q, exc_q, acc_q);

    always_comb begin
        ctrl_word = '0;
        ctrl_word[EN_LSB +: EXC_W] = en_q;
    end

    assign reg_rdata = reg_sel ? ctrl_word : status_word;

    fpsr_trap_chk #(.W(EXC_W)) u_trap (
        .flags   (exc_q),
        .enables (en_q),
        .trap    (trap_req)
    );

    logic [ACC_W-1:0] acc_bits;
    assign acc_bits = acc_q;

    p_cc_excl_r2: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !reg_we) |=> $onehot0({cc_q.z, cc_q.i, cc_q.nan}));

    p_snan_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !reg_we && upd_class == CLS_SNAN) |=> (exc_q.snan && cc_q.nan));

    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && !reg_sel) |=> ((acc_bits & $past(acc_bits)) == $past(acc_bits)));

    p_trap_r10: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !reg_we && ((upd_exc & en_q) != '0)) |=> trap_req);

    p_wr_prio_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_sel) |=> (status_word == ($past(reg_wdata) & STATUS_MASK)));
endmodule

// File: tb/fpsr_unit_tb.sv
module fpsr_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        upd_valid, upd_sign, upd_clr_exc, reg_we, reg_sel;
    logic [2:0]  upd_class;
    logic [7:0]  upd_exc;
    logic [31:0] reg_wdata, reg_rdata;
    logic        trap_req;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    fpsr_unit u_dut (
        .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_sign(upd_sign),
        .upd_class(upd_class), .upd_exc(upd_exc), .upd_clr_exc(upd_clr_exc),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trap_req(trap_req)
    );

    typedef struct packed {
        logic        sign;
        logic [2:0]  cls;
        logic [7:0]  exc;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 3'd0, 8'h00, 32'h0000_0000},
        '{1'b1, 3'd0, 8'h00, 32'h0800_0000},
        '{1'b0, 3'd1, 8'h00, 32'h0400_0000},
        '{1'b1, 3'd1, 8'h00, 32'h0C00_0000},
        '{1'b0, 3'd2, 8'h00, 32'h0200_0000},
        '{1'b1, 3'd2, 8'h00, 32'h0A00_0000},
        '{1'b0, 3'd3, 8'h00, 32'h0100_0000},
        '{1'b1, 3'd4, 8'h00, 32'h0900_4080},
        '{1'b0, 3'd0, 8'h80, 32'h0000_8080},
        '{1'b0, 3'd0, 8'h20, 32'h0000_2080},
        '{1'b0, 3'd0, 8'h10, 32'h0000_1048},
        '{1'b0, 3'd0, 8'h04, 32'h0000_0410},
        '{1'b0, 3'd0, 8'h08, 32'h0000_0800},
        '{1'b0, 3'd0, 8'h0A, 32'h0000_0A28},
        '{1'b0, 3'd0, 8'h01, 32'h0000_0108},
        '{1'b0, 3'd0, 8'h02, 32'h0000_0208}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic upd(input logic s, input logic [2:0] c, input logic [7:0] e, input logic clr);
        @(negedge clk);
        upd_valid = 1'b1; upd_sign = s; upd_class = c; upd_exc = e; upd_clr_exc = clr;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; upd_valid = 1'b0; upd_sign = 1'b0; upd_class = 3'd0;
        upd_exc = 8'h00; upd_clr_exc = 1'b1; reg_we = 1'b0; reg_sel = 1'b0;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1'b0, v); check("R1 status", v, 32'h0);
        rd(1'b1, v); check("R1 control", v, 32'h0);
        check("R1 trap", {31'b0, trap_req}, 32'h0);

        // Table: R2 R3 R5 R6 R7 R8 from a cleared status word
        for (int k = 0; k < NV; k++) begin
            wr(1'b0, 32'h0);
            upd(VECS[k].sign, VECS[k].cls, VECS[k].exc, 1'b1);
            rd(1'b0, v);
            check($sformatf("R2/R3/R5-R8 vec%0d", k), v, VECS[k].exp);
            check($sformatf("R10 no trap vec%0d", k), {31'b0, trap_req}, 32'h0);
        end

        // R4 accumulate vs replace, R9 stickiness
        wr(1'b0, 32'h0);
        upd(1'b0, 3'd0, 8'h10, 1'b1);
        rd(1'b0, v); check("R4 replace ovfl", v, 32'h0000_1048);
        upd(1'b0, 3'd0, 8'h04, 1'b0);
        rd(1'b0, v); check("R4 accumulate dz", v, 32'h0000_1458);
        upd(1'b0, 3'd1, 8'h00, 1'b1);
        rd(1'b0, v); check("R9 sticky after clear", v, 32'h0400_0058);
        wr(1'b0, 32'h0);
        rd(1'b0, v); check("R9 cleared by write", v, 32'h0);

        // R12 masks
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); check("R12 status mask", v, 32'h0F00_FFF8);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); check("R12 control mask", v, 32'h0000_FF00);
        check("R10 trap from written status", {31'b0, trap_req}, 32'h1);

        // R10 trap via enable byte: only DZ enabled
        wr(1'b1, 32'h0000_0400);
        rd(1'b1, v); check("R12 control readback", v, 32'h0000_0400);
        wr(1'b0, 32'h0);
        check("R10 trap low after clear", {31'b0, trap_req}, 32'h0);
        upd(1'b0, 3'd0, 8'h04, 1'b1);
        check("R10 trap on enabled dz", {31'b0, trap_req}, 32'h1);
        upd(1'b0, 3'd0, 8'h00, 1'b1);
        check("R10 trap drops", {31'b0, trap_req}, 32'h0);
        upd(1'b0, 3'd0, 8'h10, 1'b1);
        check("R10 disabled ovfl no trap", {31'b0, trap_req}, 32'h0);

        // R11 write beats update in the same cycle
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h0000_0000;
        upd_valid = 1'b1; upd_sign = 1'b1; upd_class = 3'd4; upd_exc = 8'hFF; upd_clr_exc = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; upd_valid = 1'b0;
        rd(1'b0, v); check("R11 write priority", v, 32'h0);
        check("R11 no trap", {31'b0, trap_req}, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule